// File: doc/BRIEF.md
# Grouped Wake-Up Event Detector

This block watches a large set of asynchronous wake-up lines, such as decoded virtual wires and a reset pin, and turns their activity into latched pending events and one interrupt line per group. Lines come in groups of eight, and groups come in tables. There are three tables of eight groups by default. Every line first passes through a two-flop synchroniser. Per-bit settings then decide what counts as an event: a rising edge, a falling edge, either edge, or an active level.

Software sets up each group through a small byte-wide register port. For each group it writes a mode byte, a polarity byte, an any-edge byte and an enable byte. It then services interrupts in three steps: read the group's pending byte, write that same value to the group's clear register, and handle the bits that were set. A new event that lands in the same cycle as the clear write stays pending, so it is never lost. The register port is plain control access with no handshake. Writes take effect on the next rising clock edge. Reads return data combinationally from the current address.

Top module: `wake_event_unit`

## Requirements
- R1: After reset, every configuration byte and every pending byte reads 0, and every group interrupt is low.
- R2: In edge mode (mode bit 0), with any-edge 0 and polarity 0, a 0-to-1 transition of a line sets its pending bit. A 1-to-0 transition does not.
- R3: In edge mode, with any-edge 0 and polarity 1, a 1-to-0 transition sets the pending bit. A 0-to-1 transition does not.
- R4: In edge mode with the any-edge bit 1, both transitions set the pending bit, whatever the polarity bit holds.
- R5: Writing a byte to a group's clear register (offset 5) clears each pending bit written as 1. Bits written as 0 are left unchanged. Writes to the pending status register (offset 4) have no effect. The clear register reads 0.
- R6: If an event and a clear of the same bit happen in the same cycle, the bit stays pending. Clearing other bits in that cycle still takes effect.
- R7: Pending bits latch regardless of the enable byte. A group's interrupt is high exactly while at least one of its pending bits is set and also enabled.
- R8: In level mode (mode bit 1), the pending bit is set in every cycle that the synchronised line is at its active level. The active level is high for polarity 0 and low for polarity 1. A clear therefore does not remove it while that level persists.
- R9: A line change made between clock edges appears in the pending byte after the third rising edge that follows it, and not after the second.
- R10: The register address is {table, group, offset[2:0]}. The offsets are: 0 mode, 1 polarity, 2 any-edge, 3 enable, 4 pending (read-only), 5 clear. Offsets 6 and 7, and any table index of NUM_TABLES or above, read 0 and ignore writes.
- R11: A write to one group's register changes no register of any other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_in | input | NUM_TABLES*GROUPS*LANE_W | Asynchronous wake lines; line b of group g in table t is bit (t*GROUPS+g)*LANE_W+b |
| reg_addr | input | TBL_W+GRP_W+3 | Register address {table, group, offset} |
| reg_we | input | 1 | Write strobe, applied on the next rising edge |
| reg_wdata | input | LANE_W | Write data |
| reg_rdata | output | LANE_W | Combinational read data for reg_addr |
| grp_irq | output | NUM_TABLES*GROUPS | Interrupt per group, index t*GROUPS+g |

## Verification
The bench builds the block with its default parameters: three tables of eight groups with eight lines each. Because the table count is not a power of two, the unused table index 3 can be addressed, and the bench checks that it reads 0 and ignores writes. Random configurations across all 24 groups mix edge and level bits within one byte, which brings the per-bit independence of mode, polarity and any-edge within reach. Directed sequences align a fresh edge with a clear write in the same cycle, and probe the exact three-edge latency of the synchroniser path.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_MODE = 3'd0,
    OFS_POL  = 3'd1,
    OFS_ANY  = 3'd2,
    OFS_EN   = 3'd3,
    OFS_PEND = 3'd4,
    OFS_CLR  = 3'd5
  } wk_ofs_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/wk_group.sv
module wk_group
  import wk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     line_s,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [W-1:0]     wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [W-1:0]     rd_data,
  output logic             irq
);
  logic [W-1:0] mode_q, pol_q, any_q, en_q, pend_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr_mask;

  always_comb begin
    rise     = line_s & ~prev_q;
    fall     = ~line_s & prev_q;
    edge_hit = (any_q & (rise | fall)) | (~any_q & ~pol_q & rise) | (~any_q & pol_q & fall);
    lvl_hit  = line_s ^ pol_q;
    hit      = (mode_q & lvl_hit) | (~mode_q & edge_hit);
    clr_mask = (wr_en && wr_ofs == OFS_CLR) ? wr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= line_s;
      pend_q <= (pend_q & ~clr_mask) | hit;
      if (wr_en) begin
        case (wr_ofs)
          OFS_MODE: mode_q <= wr_data;
          OFS_POL:  pol_q  <= wr_data;
          OFS_ANY:  any_q  <= wr_data;
          OFS_EN:   en_q   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_MODE: rd_data = mode_q;
      OFS_POL:  rd_data = pol_q;
      OFS_ANY:  rd_data = any_q;
      OFS_EN:   rd_data = en_q;
      OFS_PEND: rd_data = pend_q;
      default:  rd_data = '0;
    endcase
  end

  assign irq = |(pend_q & en_q);

  // R5: a written 1 removes a pending bit unless a new event hits it
  a_r5_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~hit)) |=> ((pend_q & $past(clr_mask & ~hit)) == '0));

  // R6: an event always lands, even against a clear
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R5: pending bits only fall after a clear write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(pend_q) & ~pend_q) & ~$past(clr_mask)) == '0));

  // R2: an edge-mode bit cannot become pending without a synchronised change
  a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(mode_q) & ~$past(line_s ^ prev_q)) == '0));

  // R7: no enabled bits means no interrupt
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/wake_event_unit.sv
module wake_event_unit
  import wk_pkg::*;
#(
  parameter int NUM_TABLES = 3,
  parameter int GROUPS     = 8,
  parameter int LANE_W     = 8,
  localparam int TBL_W  = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int ADDR_W = TBL_W + GRP_W + OFS_W,
  localparam int NGRP   = NUM_TABLES * GROUPS,
  localparam int NLINE  = NGRP * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINE-1:0]  wake_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [LANE_W-1:0] reg_wdata,
  output logic [LANE_W-1:0] reg_rdata,
  output logic [NGRP-1:0]   grp_irq
);
  logic [NLINE-1:0]  lines_s;
  logic [TBL_W-1:0]  tsel;
  logic [GRP_W-1:0]  gsel;
  logic [OFS_W-1:0]  osel;
  logic [LANE_W-1:0] rd_bus [NGRP];

  assign {tsel, gsel, osel} = reg_addr;

  wk_sync #(.W(NLINE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wake_in),
    .sync_out (lines_s)
  );

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int K = t * GROUPS + g;
      logic sel;
      assign sel = reg_we && (tsel == TBL_W'(t)) && (gsel == GRP_W'(g));

      wk_group #(.W(LANE_W)) u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (lines_s[K*LANE_W +: LANE_W]),
        .wr_en   (sel),
        .wr_ofs  (osel),
        .wr_data (reg_wdata),
        .rd_ofs  (osel),
        .rd_data (rd_bus[K]),
        .irq     (grp_irq[K])
      );
    end
  end

  always_comb begin
    int unsigned idx;
    idx = 32'(tsel) * 32'(GROUPS) + 32'(gsel);
    reg_rdata = '0;
    if (32'(tsel) < 32'(NUM_TABLES) && 32'(gsel) < 32'(GROUPS)) begin
      for (int k = 0; k < NGRP; k++) begin
        if (idx == 32'(k)) reg_rdata = rd_bus[k];
      end
    end
  end

  // R10: addresses outside the populated tables read as zero
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tsel) >= 32'(NUM_TABLES)) |-> (reg_rdata == '0));
endmodule

// File: tb/wake_event_unit_bench.sv
`timescale 1ns/1ps
module wake_event_unit_bench;
  localparam int NT = 3, NG = 8, LW = 8;
  localparam int NGRP = NT * NG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NGRP*LW-1:0] wake = '0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NGRP-1:0] irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wake_event_unit u_wake_event_unit (
    .clk(clk), .rst_n(rst_n), .wake_in(wake), .reg_addr(addr),
    .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .grp_irq(irq)
  );

  function automatic logic [7:0] edge_exp(logic [7:0] o, logic [7:0] n, logic [7:0] pol, logic [7:0] any);
    logic [7:0] r, f;
    r = n & ~o;
    f = o & ~n;
    return (any & (r | f)) | (~any & ~pol & r) | (~any & pol & f);
  endfunction

  function automatic logic [7:0] act(logic [7:0] v, logic [7:0] pol);
    return v ^ pol;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int t, int g, int o, logic [7:0] d);
    @(negedge clk);
    addr = {2'(t), 3'(g), 3'(o)};
    wdata = d;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_now(int t, int g, int o, output logic [7:0] v);
    addr = {2'(t), 3'(g), 3'(o)};
    #0.5;
    v = rdata;
  endtask

  task automatic rd(int t, int g, int o, output logic [7:0] v);
    @(negedge clk);
    rd_now(t, g, o, v);
  endtask

  task automatic set_byte(int t, int g, logic [7:0] v);
    @(negedge clk);
    wake[(t*NG+g)*LW +: LW] = v;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 0, 4, v); check("R1 pend", v, 8'h00);
    rd(2, 7, 3, v); check("R1 en", v, 8'h00);
    rd(1, 4, 0, v); check("R1 mode", v, 8'h00);
    check("R1 irq", irq, '0);

    // R9 latency, R2 rising default, R7 enable gating
    @(negedge clk);
    wake[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_now(0, 0, 4, v); check("R9 not after 2 edges", v, 8'h00);
    @(negedge clk);
    rd_now(0, 0, 4, v); check("R9 after 3 edges / R2 rise", v, 8'h01);
    check("R7 disabled no irq", irq[0], 1'b0);
    wr(0, 0, 3, 8'h01);
    rd(0, 0, 3, v); check("R10 en readback", v, 8'h01);
    check("R7 irq enabled", irq[0], 1'b1);

    // R5 clear behaviour
    wr(0, 0, 5, 8'h00);
    rd(0, 0, 4, v); check("R5 zero write keeps", v, 8'h01);
    wr(0, 0, 4, 8'h00);
    rd(0, 0, 4, v); check("R5 pend read-only", v, 8'h01);
    rd(0, 0, 5, v); check("R5 clear reads 0", v, 8'h00);
    wr(0, 0, 5, 8'h01);
    rd(0, 0, 4, v); check("R5 w1c", v, 8'h00);
    check("R7 irq drops", irq[0], 1'b0);
    set_byte(0, 0, 8'h00); settle();
    rd(0, 0, 4, v); check("R2 fall ignored", v, 8'h00);

    // R3 falling polarity
    wr(0, 1, 1, 8'hFF);
    set_byte(0, 1, 8'h0F); settle();
    rd(0, 1, 4, v); check("R3 rise ignored", v, 8'h00);
    set_byte(0, 1, 8'h05); settle();
    rd(0, 1, 4, v); check("R3 fall", v, 8'h0A);

    // R4 any-edge overrides polarity
    wr(0, 2, 2, 8'hFF);
    wr(0, 2, 1, 8'hAA);
    set_byte(0, 2, 8'h33); settle();
    rd(0, 2, 4, v); check("R4 rise any", v, 8'h33);
    wr(0, 2, 5, 8'hFF);
    set_byte(0, 2, 8'h30); settle();
    rd(0, 2, 4, v); check("R4 fall any", v, 8'h03);

    // R8 level mode
    wr(1, 0, 0, 8'h03);
    wr(1, 0, 1, 8'h02);
    wr(1, 0, 5, 8'hFF);
    rd(1, 0, 4, v); check("R8 low active pol1", v, 8'h02);
    set_byte(1, 0, 8'h03); settle();
    wr(1, 0, 5, 8'hFF);
    rd(1, 0, 4, v); check("R8 reasserts", v, 8'h01);
    set_byte(1, 0, 8'h02); settle();
    wr(1, 0, 5, 8'hFF);
    rd(1, 0, 4, v); check("R8 level gone clears", v, 8'h00);

    // R6 event in same cycle as clear
    wr(2, 5, 2, 8'hFF);
    set_byte(2, 5, 8'h01); settle();
    rd(2, 5, 4, v); check("R6 first event", v, 8'h01);
    @(negedge clk);
    wake[(2*NG+5)*LW + 1] = 1'b1;
    @(negedge clk);
    wr(2, 5, 5, v);
    rd(2, 5, 4, v); check("R6 race keeps new", v, 8'h02);
    @(negedge clk);
    wake[(2*NG+5)*LW + 1] = 1'b0;
    @(negedge clk);
    wr(2, 5, 5, 8'h02);
    rd(2, 5, 4, v); check("R6 same-bit race kept", v, 8'h02);

    // R10 holes, R11 isolation
    wr(3, 0, 3, 8'hFF);
    rd(3, 0, 3, v); check("R10 table hole", v, 8'h00);
    wr(1, 2, 6, 8'hFF);
    rd(1, 2, 6, v); check("R10 offset 6", v, 8'h00);
    wr(1, 2, 3, 8'h5A);
    rd(1, 3, 3, v); check("R11 neighbour en", v, 8'h00);
    rd(1, 2, 3, v); check("R11 own en", v, 8'h5A);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int t, g;
      logic [7:0] md, pl, an, en, o, n, e;
      t = $urandom % NT; g = $urandom % NG;
      md = 8'($urandom); pl = 8'($urandom); an = 8'($urandom); en = 8'($urandom);
      o = 8'($urandom); n = 8'($urandom);
      wr(t, g, 0, md); wr(t, g, 1, pl); wr(t, g, 2, an); wr(t, g, 3, en);
      set_byte(t, g, o); settle();
      wr(t, g, 5, 8'hFF);
      set_byte(t, g, n); settle();
      e = (~md & edge_exp(o, n, pl, an)) | (md & (act(o, pl) | act(n, pl)));
      rd(t, g, 4, v); check("R2/R3/R4/R8 random pend", v, e);
      check("R7 random irq", irq[t*NG+g], |(e & en));
    end

    finish_run();
  end
endmodule